// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter

A four-bit synchronous up-counter for programmable dividers and wider synchronous counters. A value on the parallel data inputs can be captured on any rising clock edge. Otherwise the counter steps through the sixteen binary states and returns to zero after fifteen. It can also hold its value.

There are two count enables, and both must be high for the counter to advance. Only the trickle enable gates the terminal-count flag. To build a wide counter, each stage's flag drives the trickle enable of the next stage, and every stage advances on the same clock edge.

The clear is active low. A build-time parameter selects whether it acts at once or on the next rising edge. Both variants have the same port list, and the immediate style is the default.

Top module: `cascade_count4`

## Requirements
- R1: With clear, load and neither enable low, each rising edge adds one to the count modulo 16, so 15 is followed by 0.
- R2: With clear and load inactive, a low on `en_par` or on `en_trk` keeps `q` unchanged across the edge.
- R3: A low on `load_n` with clear inactive puts `din` into `q` on the next rising edge, whatever the enables are, and it does not increment.
- R4: When `SYNC_CLR` is 0, a low on `clr_n` forces `q` to 0 at once without a clock edge, keeps it at 0 and overrides load.
- R5: When `SYNC_CLR` is 1, a low on `clr_n` leaves `q` unchanged until the next rising edge, then sets it to 0, overriding load.
- R6: `tc` is high exactly when `en_trk` is high and `q` is 15, it does not depend on `en_par`, and it follows its inputs without waiting for a clock.
- R7: When each stage's `tc` drives the next stage's `en_trk`, the stages form a wider counter that carries through all stages within one clock, including across 255 to 256 and 4095 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Active-low clear, immediate or clocked per `SYNC_CLR` |
| load_n | input | 1 | Active-low parallel load |
| din | input | WIDTH | Parallel data loaded into the count |
| en_par | input | 1 | Count enable that does not gate `tc` |
| en_trk | input | 1 | Count enable that also gates `tc` |
| q | output | WIDTH | Count value |
| tc | output | 1 | Terminal-count flag |

## Verification
The assertions check on every clock edge that load, increment, hold and clear take effect with the right precedence, and that `tc` is never high unless the trickle enable is high and the count is full. Some behaviours appear only in the bench scenarios. These are the immediate clear seen between edges, and the clocked clear that leaves the value alone until its edge. The carry across a twelve-bit chain of three stages through a full wrap is also checked only by the bench.

// File: rtl/cascade_count4.sv
module cascade_count4 #(
  parameter int WIDTH    = 4,
  parameter bit SYNC_CLR = 1'b0
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             load_n,
  input  logic [WIDTH-1:0] din,
  input  logic             en_par,
  input  logic             en_trk,
  output logic [WIDTH-1:0] q,
  output logic             tc
);
  localparam logic [WIDTH-1:0] FULL = '1;

  logic [WIDTH-1:0] nxt;

  assign nxt = !load_n            ? din :
               (en_par && en_trk) ? q + WIDTH'(1) : q;

  generate
    if (SYNC_CLR) begin : g_sync
      always_ff @(posedge clk)
        q <= !clr_n ? '0 : nxt;
    end else begin : g_async
      always_ff @(posedge clk or negedge clr_n)
        if (!clr_n) q <= '0;
        else        q <= nxt;
    end
  endgenerate

  assign tc = en_trk && (q == FULL);
endmodule

// File: rtl/cascade_count4_chk.sv
module cascade_count4_chk #(
  parameter int WIDTH    = 4,
  parameter bit SYNC_CLR = 1'b0
) (
  input logic             clk,
  input logic             clr_n,
  input logic             load_n,
  input logic [WIDTH-1:0] din,
  input logic             en_par,
  input logic             en_trk,
  input logic [WIDTH-1:0] q,
  input logic             tc
);
  assert_load_R3: assert property (@(posedge clk) disable iff (!clr_n)
    (clr_n && !load_n) |=> q == $past(din));

  assert_step_R1: assert property (@(posedge clk) disable iff (!clr_n)
    (clr_n && load_n && en_par && en_trk) |=> q == $past(q) + WIDTH'(1));

  assert_hold_R2: assert property (@(posedge clk) disable iff (!clr_n)
    (clr_n && load_n && !(en_par && en_trk)) |=> $stable(q));

  assert_flag_R6: assert property (@(posedge clk)
    tc |-> (en_trk && (&q)));

  assert_flag_gate_R6: assert property (@(posedge clk)
    !en_trk |-> !tc);

  generate
    if (SYNC_CLR) begin : g_sync
      assert_sync_clear_R5: assert property (@(posedge clk)
        !clr_n |=> q == '0);
    end else begin : g_async
      assert_async_clear_R4: assert property (@(posedge clk)
        !clr_n |-> q == '0);
    end
  endgenerate
endmodule

bind cascade_count4 cascade_count4_chk #(.WIDTH(WIDTH), .SYNC_CLR(SYNC_CLR)) u_chk (
  .clk(clk), .clr_n(clr_n), .load_n(load_n), .din(din),
  .en_par(en_par), .en_trk(en_trk), .q(q), .tc(tc)
);

// File: tb/cascade_count4_test.sv
module cascade_count4_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        clr_n, load_n, en_par, en_trk;
  logic [11:0] din;
  logic [3:0]  q0, q1, q2;
  logic        tc0, tc1, tc2;

  logic       s_clr_n, s_load_n, s_par, s_trk;
  logic [3:0] s_din, sq;
  logic       stc;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  cascade_count4 #(.WIDTH(4), .SYNC_CLR(1'b0)) uut (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .din(din[3:0]),
    .en_par(en_par), .en_trk(en_trk), .q(q0), .tc(tc0));
  cascade_count4 #(.WIDTH(4), .SYNC_CLR(1'b0)) mid (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .din(din[7:4]),
    .en_par(en_par), .en_trk(tc0), .q(q1), .tc(tc1));
  cascade_count4 #(.WIDTH(4), .SYNC_CLR(1'b0)) hi (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .din(din[11:8]),
    .en_par(en_par), .en_trk(tc1), .q(q2), .tc(tc2));
  cascade_count4 #(.WIDTH(4), .SYNC_CLR(1'b1)) usync (
    .clk(clk), .clr_n(s_clr_n), .load_n(s_load_n), .din(s_din),
    .en_par(s_par), .en_trk(s_trk), .q(sq), .tc(stc));

  function automatic int wide();
    return int'({q2, q1, q0});
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #3;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int model;
    clr_n = 1'b0; load_n = 1'b1; en_par = 1'b0; en_trk = 1'b0; din = '0;
    s_clr_n = 1'b0; s_load_n = 1'b1; s_par = 1'b0; s_trk = 1'b0; s_din = '0;
    #1;
    chk("R4 reset before any edge", wide(), 0);
    tick(); tick();
    chk("R4 reset state", wide(), 0);
    chk("R5 reset state", int'(sq), 0);
    clr_n = 1'b1; s_clr_n = 1'b1;

    // R1 R7: full sweep through the chain, including 255->256 and 4095->0
    en_par = 1'b1; en_trk = 1'b1;
    model = 0;
    for (int i = 0; i < 4200; i++) begin
      tick();
      model = (model + 1) % 4096;
      chk("R1 R7 chained count", wide(), model);
      chk("R6 R7 chained tc", int'(tc2), (model == 4095) ? 1 : 0);
    end

    // R3 load at all ones, then R6 flag against enables, R2 hold
    load_n = 1'b0; din = 12'hFFF;
    tick();
    load_n = 1'b1;
    chk("R3 load all ones", wide(), 4095);
    en_par = 1'b0; en_trk = 1'b1;
    #1;
    chk("R6 tc ignores en_par", int'(tc2), 1);
    chk("R6 stage tc", int'(tc0), 1);
    tick();
    chk("R2 hold on en_par low", wide(), 4095);
    en_par = 1'b1; en_trk = 1'b0;
    #1;
    chk("R6 tc gated by en_trk", int'(tc0), 0);
    tick();
    chk("R2 hold on en_trk low", wide(), 4095);
    en_trk = 1'b1;
    tick();
    chk("R1 R7 wrap to zero", wide(), 0);

    // R3 load wins over counting
    load_n = 1'b0; din = 12'h5A3;
    tick();
    chk("R3 load over count", wide(), 12'h5A3);
    load_n = 1'b1;

    // R4 immediate clear, over load
    load_n = 1'b0; din = 12'd7; clr_n = 1'b0;
    #1;
    chk("R4 clear without edge", wide(), 0);
    tick();
    chk("R4 clear over load", wide(), 0);
    clr_n = 1'b1; load_n = 1'b1;

    // R3 R1 R6 on the clocked-clear stage: every load value
    s_par = 1'b1; s_trk = 1'b1;
    for (int v = 0; v < 16; v++) begin
      s_load_n = 1'b0; s_din = 4'(v);
      tick();
      chk("R3 sync stage load", int'(sq), v);
      s_load_n = 1'b1;
      tick();
      chk("R1 sync stage step", int'(sq), (v + 1) % 16);
      chk("R6 sync stage tc", int'(stc), ((v + 1) % 16 == 15) ? 1 : 0);
    end

    // R5 clocked clear waits for its edge, overrides load
    s_load_n = 1'b0; s_din = 4'd9;
    tick();
    s_din = 4'd5; s_clr_n = 1'b0;
    #1;
    chk("R5 no clear before edge", int'(sq), 9);
    tick();
    chk("R5 clear over load", int'(sq), 0);
    s_clr_n = 1'b1; s_load_n = 1'b1;

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule